// File: doc/BRIEF.md
# Radio Frame Transfer Sequencer

This block sits on the host side of a packet radio that is reached through a byte-wide serial register port. It moves whole frames between local buffers and the radio without software taking part. A transmit request copies a frame from a local transmit buffer into the radio's transmit memory and starts the transmission. The block then waits for the radio's interrupt and reports one of three outcomes: success, retry limit exceeded, or timeout. When the radio signals a received frame, the block stops reception, reads the stored frame together with its link-quality and signal-strength bytes, and delivers the frame without its checksum to a local receive buffer. It then starts reception again.

Every register access is broken into single bytes. Each byte goes to an external byte-level serial master through a request/done handshake. A chip-select window stays open until a byte marked as last. A single read of the radio's interrupt status serves both transmit completion and frame reception in one pass.

Top module: `rfs_frame_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `spi_req`, `tx_busy`, `tx_done`, `rx_done` and `rx_wr_en` are low.
- R2: A transmit writes one burst to long address 0x000. The command bytes are 0x80, 0x10, followed by a header-length byte of 0, the frame length, and the payload bytes in order. `spi_last` is set on the final payload byte only. A long-address command is encoded as {1, addr[9:3]} then {addr[2:0], write, 0000}.
- R3: A requested length above 126 is sent as 126. The length byte is 126, and only payload bytes 0..125 are written.
- R4: After the burst, the trigger register (short address 0x1B) is read and written back with bit 0 set and bit 2 cleared. All other bits keep their values. A short command byte is {0, reg[5:0], write}.
- R5: The transmit completes when the interrupt status read (short 0x31) shows bit 0. The block then reads short 0x24 and pulses `tx_done` with `tx_status` 1 (retry limit exceeded) if bit 0 is set, and 0 (success) otherwise.
- R6: If no interrupt arrives within `tx_timeout` cycles of the trigger write, `tx_done` pulses with `tx_status` 2 and `tx_busy` falls.
- R7: When status bit 3 is seen, bit 2 of short 0x39 is set by read-modify-write before the length is read. It is cleared the same way after the two status bytes are read. Other bits of that register keep their values.
- R8: The length read from long 0x300 is limited to the smaller of 143 and `rx_cap`. Exactly that many bytes are read from 0x301 onward, and two status bytes follow them.
- R9: Of the limited length, all bytes except the last two are written to `rx_wr_addr` 0,1,2,... and no others. `rx_len` is that count, or 0 for lengths below 2. `rx_lqi` and `rx_rssi` are the first and second status bytes.
- R10: A status value with both bit 0 and bit 3 set, while a transmit waits, completes the transmit and services the received frame after a single status read.
- R11: A status read is triggered by a falling edge of `irq_n`. Edges during status handling are ignored.
- R12: A transmit requested while a received frame is being serviced starts only after bit 2 of 0x39 has been cleared again.
- R13: Once `spi_req` is raised, it stays high with `spi_wdata` and `spi_last` unchanged until `spi_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Radio interrupt, active low |
| tx_start | input | 1 | Transmit request pulse, ignored while busy |
| tx_len | input | 8 | Requested frame length |
| tx_rd_addr | output | 8 | Transmit buffer read address |
| tx_rd_data | input | 8 | Transmit buffer byte at tx_rd_addr, same cycle |
| tx_timeout | input | 24 | Cycles to wait for transmit completion |
| tx_busy | output | 1 | Transmit accepted and not yet finished |
| tx_done | output | 1 | One-cycle transmit completion pulse |
| tx_status | output | 2 | 0 success, 1 retry exceeded, 2 timeout |
| rx_cap | input | 8 | Receive buffer capacity in bytes |
| rx_wr_en | output | 1 | Receive buffer write strobe |
| rx_wr_addr | output | 8 | Receive buffer write address |
| rx_wr_data | output | 8 | Receive buffer write data |
| rx_done | output | 1 | One-cycle received-frame pulse |
| rx_len | output | 8 | Delivered frame length |
| rx_lqi | output | 8 | Link quality of last frame |
| rx_rssi | output | 8 | Signal strength of last frame |
| spi_req | output | 1 | Byte request to serial master |
| spi_wdata | output | 8 | Byte to shift out |
| spi_last | output | 1 | Release chip select after this byte |
| spi_done | input | 1 | Byte finished pulse |
| spi_rdata | input | 8 | Byte shifted in, valid with spi_done |

## Verification
The handshake assertion assumes two things. The serial master returns `spi_done` only while a request is outstanding, and transmit buffer contents do not change during a transmit. The timer assertion assumes `tx_timeout` is held steady while a transmit is in flight. The bench meets these assumptions in three ways. Its serial model answers only requests it has captured, and never raises done in the cycle after one. Buffer contents and the timeout value are written only while the block is idle. A radio model holds short registers and long memory and decodes each byte the block sends. Results are checked against the contents of that model rather than against internal state.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        TXR_OK      = 2'd0,
        TXR_RETRY   = 2'd1,
        TXR_TIMEOUT = 2'd2
    } txres_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_TXLOAD, ST_TRIG_RD, ST_TRIG_WR, ST_TXWAIT,
        ST_IST_RD, ST_TXST_RD, ST_BLK_RD, ST_BLK_WR,
        ST_LEN_RD, ST_FIFO_RD, ST_UNB_RD, ST_UNB_WR
    } seq_e;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] lqi;
        logic [7:0] rssi;
    } rxinfo_t;

    // radio register addresses the sequencer must hit
    localparam logic [5:0] REG_TRIG   = 6'h1B;
    localparam logic [5:0] REG_TXRES  = 6'h24;
    localparam logic [5:0] REG_ISTAT  = 6'h31;
    localparam logic [5:0] REG_RXGATE = 6'h39;
    localparam logic [9:0] ADR_TXBUF  = 10'h000;
    localparam logic [9:0] ADR_RXLEN  = 10'h300;
    localparam logic [9:0] ADR_RXDAT  = 10'h301;

    function automatic logic [7:0] short_cmd(input logic [5:0] r, input logic wr);
        return {1'b0, r, wr};
    endfunction

    function automatic logic [7:0] long_hi(input logic [9:0] a);
        return {1'b1, a[9:3]};
    endfunction

    function automatic logic [7:0] long_lo(input logic [9:0] a, input logic wr);
        return {a[2:0], wr, 4'b0000};
    endfunction

    function automatic logic [7:0] clamp_len(input logic [7:0] v, input logic [7:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/rfs_irq_edge.sv
module rfs_irq_edge (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    input  logic mask,
    input  logic clr,
    output logic pend
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            s3   <= 1'b1;
            pend <= 1'b0;
        end else begin
            s1 <= irq_n;
            s2 <= s1;
            s3 <= s2;
            if (clr)
                pend <= 1'b0;
            else if (s3 && !s2 && !mask)
                pend <= 1'b1;
        end
    end

    // R11: a pending request never appears from an edge seen while masked
    a_r11_masked_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> !$past(mask));

endmodule

// File: rtl/rfs_wait_timer.sv
module rfs_wait_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end

    // R6: once reached, expiry persists until the next start
    a_r6_expiry_holds: assert property (@(posedge clk) disable iff (rst)
        (run && expired && !start) |=> expired);

endmodule

// File: rtl/rfs_len_clamp.sv
module rfs_len_clamp import rfs_pkg::*; #(
    parameter int LIM  = 143,
    parameter int DROP = 2
) (
    input  logic [7:0] raw,
    input  logic [7:0] cap,
    output logic [7:0] take,
    output logic [7:0] keep
);
    localparam logic [7:0] LIM8  = 8'(LIM);
    localparam logic [7:0] DROP8 = 8'(DROP);

    assign take = clamp_len(clamp_len(raw, LIM8), cap);
    assign keep = (take >= DROP8) ? (take - DROP8) : 8'd0;

    // R8: the accepted length respects both limits
    always_comb begin
        a_r8_take_bound: assert (take <= LIM8 && take <= cap && keep <= take);
    end

endmodule

// File: rtl/rfs_frame_seq.sv
module rfs_frame_seq import rfs_pkg::*; #(
    parameter int TX_MAX = 126,
    parameter int RX_MAX = 143,
    parameter int TMR_W  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_n,
    input  logic             tx_start,
    input  logic [7:0]       tx_len,
    output logic [7:0]       tx_rd_addr,
    input  logic [7:0]       tx_rd_data,
    input  logic [TMR_W-1:0] tx_timeout,
    output logic             tx_busy,
    output logic             tx_done,
    output logic [1:0]       tx_status,
    input  logic [7:0]       rx_cap,
    output logic             rx_wr_en,
    output logic [7:0]       rx_wr_addr,
    output logic [7:0]       rx_wr_data,
    output logic             rx_done,
    output logic [7:0]       rx_len,
    output logic [7:0]       rx_lqi,
    output logic [7:0]       rx_rssi,
    output logic             spi_req,
    output logic [7:0]       spi_wdata,
    output logic             spi_last,
    input  logic             spi_done,
    input  logic [7:0]       spi_rdata
);
    localparam logic [7:0] TX_LIM  = 8'(TX_MAX);
    localparam logic [7:0] HDR_TX  = 8'd4;  // command(2) + header length + length
    localparam logic [7:0] HDR_RX  = 8'd2;  // command(2)

    seq_e       state;
    logic [7:0] idx, scr, ntx, nrx, nkeep;
    logic       txw, tx_pend, rx_flag, gate_on;
    txres_e     tx_res;
    rxinfo_t    rxi;
    logic       irq_pend, svc, irq_clr, tmr_exp, tmr_start;
    logic       blast;
    logic [7:0] rx_take, rx_keep;

    // ---------------- helpers ----------------
    rfs_irq_edge u_irq (
        .clk(clk), .rst(rst), .irq_n(irq_n),
        .mask(svc), .clr(irq_clr), .pend(irq_pend)
    );

    rfs_wait_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .start(tmr_start), .run(txw),
        .limit(tx_timeout), .expired(tmr_exp)
    );

    rfs_len_clamp #(.LIM(RX_MAX), .DROP(2)) u_rxlen (
        .raw(spi_rdata), .cap(rx_cap), .take(rx_take), .keep(rx_keep)
    );

    assign svc = !(state inside {ST_IDLE, ST_TXLOAD, ST_TRIG_RD, ST_TRIG_WR, ST_TXWAIT});
    assign irq_clr   = (state == ST_IDLE || state == ST_TXWAIT) && irq_pend;
    assign tmr_start = (state == ST_TRIG_WR) && spi_done && blast;

    assign tx_busy    = tx_pend | txw;
    assign tx_status  = tx_res;
    assign tx_rd_addr = idx - HDR_TX;
    assign rx_len     = rxi.len;
    assign rx_lqi     = rxi.lqi;
    assign rx_rssi    = rxi.rssi;

    assign rx_wr_en   = (state == ST_FIFO_RD) && spi_done && (idx >= HDR_RX)
                        && ((idx - HDR_RX) < nkeep);
    assign rx_wr_addr = idx - HDR_RX;
    assign rx_wr_data = spi_rdata;

    // ---------------- byte generator ----------------
    always_comb begin
        spi_req   = 1'b1;
        spi_wdata = 8'h00;
        blast     = (idx == 8'd1);
        case (state)
            ST_IDLE, ST_TXWAIT: begin
                spi_req = 1'b0;
                blast   = 1'b0;
            end
            ST_TXLOAD: begin
                blast = (idx == ntx + 8'd3);
                case (idx)
                    8'd0:    spi_wdata = long_hi(ADR_TXBUF);
                    8'd1:    spi_wdata = long_lo(ADR_TXBUF, 1'b1);
                    8'd2:    spi_wdata = 8'h00;
                    8'd3:    spi_wdata = ntx;
                    default: spi_wdata = tx_rd_data;
                endcase
            end
            ST_TRIG_RD: spi_wdata = (idx == 8'd0) ? short_cmd(REG_TRIG, 1'b0) : 8'h00;
            ST_TRIG_WR: spi_wdata = (idx == 8'd0) ? short_cmd(REG_TRIG, 1'b1)
                                                  : ((scr | 8'h01) & 8'hFB);
            ST_IST_RD:  spi_wdata = (idx == 8'd0) ? short_cmd(REG_ISTAT, 1'b0) : 8'h00;
            ST_TXST_RD: spi_wdata = (idx == 8'd0) ? short_cmd(REG_TXRES, 1'b0) : 8'h00;
            ST_BLK_RD, ST_UNB_RD:
                        spi_wdata = (idx == 8'd0) ? short_cmd(REG_RXGATE, 1'b0) : 8'h00;
            ST_BLK_WR:  spi_wdata = (idx == 8'd0) ? short_cmd(REG_RXGATE, 1'b1) : (scr | 8'h04);
            ST_UNB_WR:  spi_wdata = (idx == 8'd0) ? short_cmd(REG_RXGATE, 1'b1) : (scr & 8'hFB);
            ST_LEN_RD: begin
                blast = (idx == 8'd2);
                case (idx)
                    8'd0:    spi_wdata = long_hi(ADR_RXLEN);
                    8'd1:    spi_wdata = long_lo(ADR_RXLEN, 1'b0);
                    default: spi_wdata = 8'h00;
                endcase
            end
            ST_FIFO_RD: begin
                blast = (idx == nrx + 8'd3);
                case (idx)
                    8'd0:    spi_wdata = long_hi(ADR_RXDAT);
                    8'd1:    spi_wdata = long_lo(ADR_RXDAT, 1'b0);
                    default: spi_wdata = 8'h00;
                endcase
            end
            default: begin
                spi_req = 1'b0;
                blast   = 1'b0;
            end
        endcase
        spi_last = blast;
    end

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            scr     <= '0;
            ntx     <= '0;
            nrx     <= '0;
            nkeep   <= '0;
            txw     <= 1'b0;
            tx_pend <= 1'b0;
            rx_flag <= 1'b0;
            gate_on <= 1'b0;
            tx_done <= 1'b0;
            tx_res  <= TXR_OK;
            rx_done <= 1'b0;
            rxi     <= '0;
        end else begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
            if (tx_start && !tx_busy) begin
                tx_pend <= 1'b1;
                ntx     <= clamp_len(tx_len, TX_LIM);
            end
            case (state)
                ST_IDLE: begin
                    if (irq_pend)
                        state <= ST_IST_RD;
                    else if (tx_pend) begin
                        state   <= ST_TXLOAD;
                        tx_pend <= 1'b0;
                        txw     <= 1'b1;
                    end
                end
                ST_TXWAIT: begin
                    if (irq_pend)
                        state <= ST_IST_RD;
                    else if (tmr_exp) begin
                        tx_done <= 1'b1;
                        tx_res  <= TXR_TIMEOUT;
                        txw     <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: if (spi_done) begin
                    idx <= blast ? 8'd0 : idx + 8'd1;
                    if (state == ST_FIFO_RD && idx == nrx + 8'd2)
                        rxi.lqi <= spi_rdata;
                    if (blast) begin
                        case (state)
                            ST_TXLOAD:  state <= ST_TRIG_RD;
                            ST_TRIG_RD: begin scr <= spi_rdata; state <= ST_TRIG_WR; end
                            ST_TRIG_WR: state <= ST_TXWAIT;
                            ST_IST_RD: begin
                                rx_flag <= spi_rdata[3];
                                if (spi_rdata[0] && txw)
                                    state <= ST_TXST_RD;
                                else if (spi_rdata[3])
                                    state <= ST_BLK_RD;
                                else
                                    state <= txw ? ST_TXWAIT : ST_IDLE;
                            end
                            ST_TXST_RD: begin
                                tx_done <= 1'b1;
                                tx_res  <= spi_rdata[0] ? TXR_RETRY : TXR_OK;
                                txw     <= 1'b0;
                                state   <= rx_flag ? ST_BLK_RD : ST_IDLE;
                            end
                            ST_BLK_RD:  begin scr <= spi_rdata; state <= ST_BLK_WR; end
                            ST_BLK_WR:  begin gate_on <= 1'b1; state <= ST_LEN_RD; end
                            ST_LEN_RD: begin
                                nrx   <= rx_take;
                                nkeep <= rx_keep;
                                state <= ST_FIFO_RD;
                            end
                            ST_FIFO_RD: begin
                                rxi.rssi <= spi_rdata;
                                rxi.len  <= nkeep;
                                state    <= ST_UNB_RD;
                            end
                            ST_UNB_RD:  begin scr <= spi_rdata; state <= ST_UNB_WR; end
                            ST_UNB_WR: begin
                                gate_on <= 1'b0;
                                rx_done <= 1'b1;
                                state   <= txw ? ST_TXWAIT : ST_IDLE;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R13: a byte request is held steady until the master answers
    a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_done) |=> (spi_req && $stable(spi_wdata) && $stable(spi_last)));

    // R5: a reported transmit leaves the sequencer free for the next one
    a_r5_done_frees: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_busy);

    // R12: transmit loading never overlaps blocked reception
    a_r12_no_load_gated: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TXLOAD) |-> !gate_on);

    // R9: delivered bytes stay below the largest checksum-free length
    a_r9_wr_bound: assert property (@(posedge clk) disable iff (rst)
        rx_wr_en |-> (rx_wr_addr < 8'(RX_MAX - 2)));

    // R3: payload fetches stay inside the truncated frame
    a_r3_fetch_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TXLOAD && idx >= HDR_TX && spi_req) |-> (tx_rd_addr < TX_LIM));

endmodule

// File: tb/sim_rfs_frame_seq.sv
module sim_rfs_frame_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_n = 1'b1;
    logic        tx_start = 1'b0;
    logic [7:0]  tx_len = 8'd0;
    logic [7:0]  tx_rd_addr;
    logic [7:0]  tx_rd_data;
    logic [23:0] tx_timeout = 24'd5000;
    logic        tx_busy, tx_done;
    logic [1:0]  tx_status;
    logic [7:0]  rx_cap = 8'd255;
    logic        rx_wr_en;
    logic [7:0]  rx_wr_addr, rx_wr_data;
    logic        rx_done;
    logic [7:0]  rx_len, rx_lqi, rx_rssi;
    logic        spi_req, spi_last;
    logic [7:0]  spi_wdata;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rdata = 8'h00;

    always #4 clk = ~clk;  // 125 MHz

    logic [7:0] sreg [64];
    logic [7:0] lmem [1024];
    logic [7:0] txbuf [256];
    logic [7:0] rxbuf [256];

    assign tx_rd_data = txbuf[tx_rd_addr];

    rfs_frame_seq u0 (
        .clk(clk), .rst(rst), .irq_n(irq_n),
        .tx_start(tx_start), .tx_len(tx_len), .tx_rd_addr(tx_rd_addr),
        .tx_rd_data(tx_rd_data), .tx_timeout(tx_timeout),
        .tx_busy(tx_busy), .tx_done(tx_done), .tx_status(tx_status),
        .rx_cap(rx_cap), .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr),
        .rx_wr_data(rx_wr_data), .rx_done(rx_done), .rx_len(rx_len),
        .rx_lqi(rx_lqi), .rx_rssi(rx_rssi),
        .spi_req(spi_req), .spi_wdata(spi_wdata), .spi_last(spi_last),
        .spi_done(spi_done), .spi_rdata(spi_rdata)
    );

    int total = 0, bad = 0;
    int ist_reads = 0, trig_writes = 0, viol = 0, gate_bad = 0, hs_bad = 0;
    int txd_seen = 0, rxd_seen = 0, txd_stat = 0;
    int rxd_len = 0, rxd_lqi = 0, rxd_rssi = 0;

    // radio and serial-master model state
    bit         m_busy = 0, m_l = 0;
    int         m_cnt = 0, m_pos = 0;
    logic [7:0] m_b = 0, m_b0 = 0, m_b1 = 0, m_resp = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task model_step();
        if (rx_wr_en) rxbuf[rx_wr_addr] = rx_wr_data;
        if (tx_done) begin txd_seen++; txd_stat = int'(tx_status); end
        if (rx_done) begin
            rxd_seen++; rxd_len = int'(rx_len); rxd_lqi = int'(rx_lqi); rxd_rssi = int'(rx_rssi);
        end
        if (rst) begin
            m_busy = 0; m_pos = 0; spi_done <= 1'b0;
        end else if (spi_done) begin
            spi_done <= 1'b0; m_busy = 0;
        end else if (m_busy) begin
            if (!spi_req) hs_bad++;
            if (m_cnt == 0) begin
                m_resp = 8'h00;
                if (m_pos == 0) m_b0 = m_b;
                else if (m_pos == 1) begin
                    m_b1 = m_b;
                    if (!m_b0[7]) begin
                        if (m_b0[0]) begin
                            sreg[m_b0[6:1]] = m_b;
                            if (m_b0[6:1] == 6'h1B) trig_writes++;
                        end else begin
                            m_resp = sreg[m_b0[6:1]];
                            if (m_b0[6:1] == 6'h31) begin ist_reads++; sreg[6'h31] = 8'h00; end
                        end
                    end
                end else if (m_b0[7]) begin
                    int a;
                    a = ({m_b0[6:0], m_b1[7:5]} + m_pos - 2) & 1023;
                    if (m_b1[4]) begin
                        lmem[a] = m_b;
                        if (sreg[6'h39][2]) viol++;
                    end else begin
                        m_resp = lmem[a];
                        if (a >= 'h300 && !sreg[6'h39][2]) gate_bad++;
                    end
                end
                m_pos = m_l ? 0 : m_pos + 1;
                spi_rdata <= m_resp;
                spi_done  <= 1'b1;
            end else m_cnt--;
        end else if (spi_req) begin
            m_busy = 1; m_b = spi_wdata; m_l = spi_last; m_cnt = 2;
        end
    endtask

    task automatic pulse_irq(logic [7:0] v);
        sreg[6'h31] = v;
        irq_n = 1'b0;
        repeat (6) @(negedge clk);
        irq_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_tx(int len);
        tx_len = 8'(len);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic wait_trig(int base, string tag);
        int n = 0;
        while (trig_writes == base && n < 4000) begin @(negedge clk); n++; end
        if (n >= 4000) chk({tag, " trigger write"}, 0, 1);
    endtask

    task automatic wait_tx(int base, string tag);
        int n = 0;
        while (txd_seen == base && n < 4000) begin @(negedge clk); n++; end
        if (n >= 4000) chk({tag, " tx_done seen"}, 0, 1);
    endtask

    task automatic wait_rx(int base, string tag);
        int n = 0;
        while (rxd_seen == base && n < 4000) begin @(negedge clk); n++; end
        if (n >= 4000) chk({tag, " rx_done seen"}, 0, 1);
    endtask

    task automatic wait_gate();
        int n = 0;
        while (!sreg[6'h39][2] && n < 4000) begin @(negedge clk); n++; end
    endtask

    task automatic fill_tx();
        for (int i = 0; i < 256; i++) txbuf[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 256; i++) lmem[i] = 8'hEE;
    endtask

    task automatic setup_rx(int l, int cap);
        lmem['h300] = 8'(l);
        for (int i = 0; i < 200; i++) lmem['h301 + i] = 8'(i ^ 'h5A);
        for (int i = 0; i < 256; i++) rxbuf[i] = 8'hAA;
        rx_cap = 8'(cap);
        sreg[6'h39] = 8'h41;
    endtask

    task automatic check_rx(int l, int cap, string tag);
        int take, keep, mism;
        take = (l > 143) ? 143 : l;
        if (take > cap) take = cap;
        keep = (take >= 2) ? take - 2 : 0;
        mism = 0;
        for (int i = 0; i < keep; i++) if (rxbuf[i] != lmem['h301 + i]) mism++;
        chk({tag, " R9 rx_len"}, rxd_len, keep);
        chk({tag, " R9 payload mismatches"}, mism, 0);
        chk({tag, " R9 no write past length"}, int'(rxbuf[keep]), 'hAA);
        chk({tag, " R8 R9 lqi after clamped length"}, rxd_lqi, int'(lmem['h301 + take]));
        chk({tag, " R8 rssi"}, rxd_rssi, int'(lmem['h302 + take]));
        chk({tag, " R7 gate restored"}, int'(sreg[6'h39]), 'h41);
        chk({tag, " R7 reads while gated"}, gate_bad, 0);
    endtask

    // ---------- scenarios ----------
    task automatic t_reset();
        chk("R1 spi_req", int'(spi_req), 0);
        chk("R1 tx_busy", int'(tx_busy), 0);
        chk("R1 done pulses", int'(tx_done | rx_done), 0);
        chk("R1 rx_wr_en", int'(rx_wr_en), 0);
    endtask

    task automatic t_tx_ok();
        int t0 = trig_writes, d0 = txd_seen, i0 = ist_reads, mism = 0;
        fill_tx();
        sreg[6'h1B] = 8'h84; sreg[6'h24] = 8'h00;
        pulse_tx(5);
        wait_trig(t0, "R2");
        chk("R2 header length byte", int'(lmem[0]), 0);
        chk("R2 length byte", int'(lmem[1]), 5);
        for (int i = 0; i < 5; i++) if (lmem[2 + i] != txbuf[i]) mism++;
        chk("R2 payload mismatches", mism, 0);
        chk("R2 burst ends at length", int'(lmem[7]), 'hEE);
        chk("R4 trigger set/clear", int'(sreg[6'h1B]), 'h81);
        chk("R5 busy while waiting", int'(tx_busy), 1);
        pulse_irq(8'h01);
        wait_tx(d0, "R5");
        chk("R5 success status", txd_stat, 0);
        chk("R5 one status read", ist_reads - i0, 1);
        chk("R5 busy released", int'(tx_busy), 0);
    endtask

    task automatic t_tx_fail();
        int t0 = trig_writes, d0 = txd_seen;
        fill_tx();
        sreg[6'h1B] = 8'hF6; sreg[6'h24] = 8'h01;
        pulse_tx(9);
        wait_trig(t0, "R4");
        chk("R4 other bits kept", int'(sreg[6'h1B]), 'hF3);
        pulse_irq(8'h01);
        wait_tx(d0, "R5");
        chk("R5 retry failure status", txd_stat, 1);
    endtask

    task automatic t_tx_trunc();
        int t0 = trig_writes, d0 = txd_seen;
        fill_tx();
        sreg[6'h24] = 8'h00;
        pulse_tx(200);
        wait_trig(t0, "R3");
        chk("R3 length clamped", int'(lmem[1]), 126);
        chk("R3 last payload byte", int'(lmem[127]), int'(txbuf[125]));
        chk("R3 nothing beyond", int'(lmem[128]), 'hEE);
        pulse_irq(8'h01);
        wait_tx(d0, "R3");
        chk("R3 completes ok", txd_stat, 0);
    endtask

    task automatic t_tx_timeout();
        int t0 = trig_writes, d0 = txd_seen;
        fill_tx();
        tx_timeout = 24'd40;
        pulse_tx(3);
        wait_trig(t0, "R6");
        wait_tx(d0, "R6");
        chk("R6 timeout status", txd_stat, 2);
        @(negedge clk);
        chk("R6 busy released", int'(tx_busy), 0);
        tx_timeout = 24'd5000;
    endtask

    task automatic t_rx(int l, int cap, string tag);
        int r0 = rxd_seen;
        setup_rx(l, cap);
        pulse_irq(8'h08);
        wait_rx(r0, tag);
        check_rx(l, cap, tag);
    endtask

    task automatic t_both();
        int t0 = trig_writes, d0 = txd_seen, r0 = rxd_seen, i0 = ist_reads;
        fill_tx();
        sreg[6'h24] = 8'h00;
        pulse_tx(4);
        wait_trig(t0, "R10");
        setup_rx(6, 255);
        pulse_irq(8'h09);
        wait_tx(d0, "R10");
        wait_rx(r0, "R10");
        chk("R10 single status read", ist_reads - i0, 1);
        chk("R10 tx ok", txd_stat, 0);
        check_rx(6, 255, "R10");
    endtask

    task automatic t_mask();
        int r0 = rxd_seen, i0 = ist_reads;
        setup_rx(100, 255);
        pulse_irq(8'h08);
        wait_gate();
        pulse_irq(8'h08);   // second edge during service
        wait_rx(r0, "R11");
        repeat (300) @(negedge clk);
        chk("R11 edge in service ignored", ist_reads - i0, 1);
        chk("R11 one frame serviced", rxd_seen - r0, 1);
        sreg[6'h31] = 8'h00;
    endtask

    task automatic t_tx_during_rx();
        int r0 = rxd_seen, d0 = txd_seen, t0 = trig_writes, v0 = viol;
        fill_tx();
        setup_rx(60, 255);
        sreg[6'h24] = 8'h00;
        pulse_irq(8'h08);
        wait_gate();
        pulse_tx(8);
        wait_rx(r0, "R12");
        chk("R12 no trigger before rx end", trig_writes - t0, 0);
        wait_trig(t0, "R12");
        chk("R12 no load while gated", viol - v0, 0);
        chk("R12 frame loaded", int'(lmem[1]), 8);
        pulse_irq(8'h01);
        wait_tx(d0, "R12");
        chk("R12 tx ok", txd_stat, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) sreg[i] = 8'h00;
        for (int i = 0; i < 1024; i++) lmem[i] = 8'h00;
        for (int i = 0; i < 256; i++) begin txbuf[i] = 8'h00; rxbuf[i] = 8'h00; end
        fork
            forever begin @(posedge clk); model_step(); end
            begin
                repeat (150000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_ok();
        t_tx_fail();
        t_tx_trunc();
        t_tx_timeout();
        t_rx(10, 255, "R9 basic");
        t_rx(200, 255, "R8 cap143");
        t_rx(20, 10, "R8 capbuf");
        t_rx(1, 255, "R9 short");
        t_both();
        t_mask();
        t_tx_during_rx();
        chk("R13 request held until done", hs_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule